// File: doc/BRIEF.md
# Lock-Protected Clock Configuration Register

This block is a single 32-bit configuration word on a simple synchronous bus. It holds the clock settings for a clock tree. These are two audio-serial clock source selects, the input select and ratio of the first pre-divider, the ratio of the second pre-divider, and the multiplier codes of two auxiliary PLLs. Firmware writes it with byte, half-word or word accesses, using per-lane strobes. Reads return the stored word in the same cycle, and the unused upper bits always read as zero.

Some fields feed a PLL that may be running. Each such field is guarded by a write-lock tied to the run state of that PLL. A write that reaches a locked field leaves that field unchanged. Other fields in the same access still take their new values. The two multiplier codes are also decoded into integer factors. A reserved code drops the factor's valid output, raises an error output and forces the factor to zero.

Top module: `clkcfg_lockreg`

## Requirements
- R1: After reset the stored word is zero. A read at the register offset returns 0x00000000, and both multiplier decoders report a reserved code (ok=0, err=1, factor 0).
- R2: Bits 31:19 always read as 0, even after a write of all ones to them.
- R3: A write updates only the byte lanes whose strobe bit is set (strobe bit n covers data bits 8n+7:8n). Lanes with a clear strobe keep their value.
- R4: Bit 16 (pre-divider A input select: 0 external oscillator, 1 PLL B output) keeps its value during any write while `pll_main_on` is 1.
- R5: Bits 15:12 (PLL C multiplier code) keep their value during any write while `pll_c_on` is 1.
- R6: Bits 11:8 (PLL B multiplier code) keep their value during any write while `pll_b_on` is 1.
- R7: A locked field does not block the other fields of the same access. Bits 18, 17, 7:4 and 3:0 are never locked, and an unlocked multiplier field in the same lane still updates.
- R8: Multiplier codes 6 to 12 decode to factor code+2, code 14 decodes to 16 and code 15 decodes to 20. In each case ok=1 and err=0. The factor is 5 bits wide, and the same table applies to the PLL B and PLL C fields.
- R9: Multiplier codes 0 to 5 and 13 are reserved and give ok=0, err=1 and factor 0.
- R10: `bus_rdata` shows the stored word in the same cycle that `bus_sel`=1, `bus_wr`=0 and `bus_addr` equals the offset (0x2C). Otherwise it is 0. A write to any other address changes nothing.
- R11: The outputs follow the stored bits directly: `aud1_clk_sel`=bit 18, `aud0_clk_sel`=bit 17, `diva_src_sel`=bit 16, `divb_ratio`=bits 7:4, `diva_ratio`=bits 3:0. For the audio selects, 0 means system clock and 1 means the PLL C VCO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Per-byte write strobes |
| bus_rdata | output | 32 | Read data, same cycle |
| pll_main_on | input | 1 | Main PLL running, locks bit 16 |
| pll_b_on | input | 1 | PLL B running, locks bits 11:8 |
| pll_c_on | input | 1 | PLL C running, locks bits 15:12 |
| aud0_clk_sel | output | 1 | First audio clock source |
| aud1_clk_sel | output | 1 | Second audio clock source |
| diva_src_sel | output | 1 | Pre-divider A input select |
| diva_ratio | output | 4 | Pre-divider A ratio code |
| divb_ratio | output | 4 | Pre-divider B ratio code |
| mulb_factor | output | 5 | PLL B multiplication factor |
| mulb_ok | output | 1 | PLL B code valid |
| mulb_err | output | 1 | PLL B code reserved |
| mulc_factor | output | 5 | PLL C multiplication factor |
| mulc_ok | output | 1 | PLL C code valid |
| mulc_err | output | 1 | PLL C code reserved |

## Verification
Two things can land in one access: a lock that holds one field, and an update to another field. A single write can touch both PLL multiplier codes in lane 1 while only one PLL is running. A write to lane 2 can also change both audio selects while the main PLL holds bit 16. The bench provokes both cases on purpose. It judges them by reading the word back and looking at the decoded outputs: the locked field must keep its old value and its neighbour must take the new one. A reference word kept in the bench gives the expected value.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
// Shared constants for the clock configuration register: the field layout
// and the lock source of each field. Assumes fields never straddle a byte lane.
package clkcfg_pkg;
    localparam int CFG_W    = 19;  // implemented bits, the rest read zero
    localparam int NFIELD   = 7;
    localparam int CODE_W   = 4;
    localparam int FACTOR_W = 5;

    // lock sources: index into the lock vector built in the top
    localparam int LK_NONE = 0;
    localparam int LK_MAIN = 1;
    localparam int LK_B    = 2;
    localparam int LK_C    = 3;
    localparam int NLOCK   = 4;

    // field order: div A ratio, div B ratio, mul B, mul C, div A src, aud0, aud1
    localparam int FLD_LSB  [NFIELD] = '{0, 4, 8, 12, 16, 17, 18};
    localparam int FLD_W    [NFIELD] = '{4, 4, 4, 4, 1, 1, 1};
    localparam int FLD_LOCK [NFIELD] = '{LK_NONE, LK_NONE, LK_B, LK_C,
                                         LK_MAIN, LK_NONE, LK_NONE};

    localparam int POS_MULB = 8;
    localparam int POS_MULC = 12;
endpackage

// File: rtl/clkcfg_bus_dec.sv
`timescale 1ns/1ps
// Bus decoder: turns one access into per-lane write enables and a read hit.
// Assumes a single-cycle bus with no wait states.
module clkcfg_bus_dec #(
    parameter int                  ADDR_W = 8,
    parameter int                  LANES  = 4,
    parameter logic [ADDR_W-1:0]   OFFSET = 8'h2C
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  strb,
    output logic [LANES-1:0]  lane_we,
    output logic              rd_hit
);
    logic hit;

    // Address match for this register.
    always_comb hit = sel && (addr == OFFSET);

    // Lane enables for writes and hit for reads.
    always_comb begin
        lane_we = (hit && wr) ? strb : '0;
        rd_hit  = hit && !wr;
    end
endmodule

// File: rtl/clkcfg_field.sv
`timescale 1ns/1ps
// One storage field: loads on its lane enable unless its lock is held.
// Assumes the lock input is already synchronous to clk.
module clkcfg_field #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         lock,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Storage with reset to zero and a lock-gated load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we && !lock)
            q <= d;
    end
endmodule

// File: rtl/clkcfg_mul_dec.sv
`timescale 1ns/1ps
// Multiplier decoder: maps a 4-bit code onto a sparse factor table.
// Reserved codes give factor 0 with ok low.
module clkcfg_mul_dec
    import clkcfg_pkg::*;
(
    input  logic [CODE_W-1:0]   code,
    output logic [FACTOR_W-1:0] factor,
    output logic                ok
);
    // Table lookup: a run of contiguous codes plus two sparse entries.
    always_comb begin
        factor = '0;
        ok     = 1'b0;
        if (code >= 4'd6 && code <= 4'd12) begin
            factor = {1'b0, code} + 5'd2;
            ok     = 1'b1;
        end else if (code == 4'd14) begin
            factor = 5'd16;
            ok     = 1'b1;
        end else if (code == 4'd15) begin
            factor = 5'd20;
            ok     = 1'b1;
        end
    end
endmodule

// File: rtl/clkcfg_lockreg.sv
`timescale 1ns/1ps
// Clock configuration register with per-field write locks tied to PLL run
// state. It decodes both multiplier codes. Assumes the PLL status inputs are
// synchronous to clk and the bus is single-cycle.
module clkcfg_lockreg
    import clkcfg_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter int                DATA_W = 32,
    parameter logic [ADDR_W-1:0] OFFSET = 8'h2C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W/8-1:0] bus_wstrb,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                pll_main_on,
    input  logic                pll_b_on,
    input  logic                pll_c_on,
    output logic                aud0_clk_sel,
    output logic                aud1_clk_sel,
    output logic                diva_src_sel,
    output logic [3:0]          diva_ratio,
    output logic [3:0]          divb_ratio,
    output logic [FACTOR_W-1:0] mulb_factor,
    output logic                mulb_ok,
    output logic                mulb_err,
    output logic [FACTOR_W-1:0] mulc_factor,
    output logic                mulc_ok,
    output logic                mulc_err
);
    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0] lane_we;
    logic             rd_hit;
    logic [NLOCK-1:0] lock_vec;
    logic [CFG_W-1:0] cfg_q;

    clkcfg_bus_dec #(.ADDR_W(ADDR_W), .LANES(LANES), .OFFSET(OFFSET)) u_dec (
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .strb    (bus_wstrb),
        .lane_we (lane_we),
        .rd_hit  (rd_hit)
    );

    // Lock vector indexed by each field's lock source.
    always_comb lock_vec = {pll_c_on, pll_b_on, pll_main_on, 1'b0};

    // One storage field per table entry, enabled by the lane it sits in.
    for (genvar f = 0; f < NFIELD; f++) begin : g_fld
        localparam int LSB = FLD_LSB[f];
        localparam int W   = FLD_W[f];
        clkcfg_field #(.W(W)) u_fld (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (lane_we[LSB/8]),
            .lock  (lock_vec[FLD_LOCK[f]]),
            .d     (bus_wdata[LSB +: W]),
            .q     (cfg_q[LSB +: W])
        );
    end

    // Two multiplier decoders built from one template.
    logic [CODE_W-1:0]   mul_code [2];
    logic [FACTOR_W-1:0] mul_fac  [2];
    logic                mul_ok   [2];

    always_comb begin
        mul_code[0] = cfg_q[POS_MULB +: CODE_W];
        mul_code[1] = cfg_q[POS_MULC +: CODE_W];
    end

    for (genvar m = 0; m < 2; m++) begin : g_mul
        clkcfg_mul_dec u_md (
            .code   (mul_code[m]),
            .factor (mul_fac[m]),
            .ok     (mul_ok[m])
        );
    end

    // Same-cycle read mux: the zero-extended word on a hit, else zero.
    always_comb bus_rdata = rd_hit ? {{(DATA_W-CFG_W){1'b0}}, cfg_q} : '0;

    // Direct field outputs and decoded factors.
    always_comb begin
        diva_ratio   = cfg_q[3:0];
        divb_ratio   = cfg_q[7:4];
        diva_src_sel = cfg_q[16];
        aud0_clk_sel = cfg_q[17];
        aud1_clk_sel = cfg_q[18];
        mulb_factor  = mul_fac[0];
        mulb_ok      = mul_ok[0];
        mulb_err     = !mul_ok[0];
        mulc_factor  = mul_fac[1];
        mulc_ok      = mul_ok[1];
        mulc_err     = !mul_ok[1];
    end
endmodule

// File: rtl/clkcfg_chk.sv
`timescale 1ns/1ps
// Checker for clkcfg_lockreg: watches the ports for lock, strobe, decode and
// read-data rules. Attached by bind, so it needs no instance in the design.
module clkcfg_chk #(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFFSET = 8'h2C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_wstrb,
    input logic [31:0]       bus_rdata,
    input logic              pll_main_on,
    input logic              pll_b_on,
    input logic              pll_c_on,
    input logic              diva_src_sel,
    input logic [3:0]        diva_ratio,
    input logic [3:0]        divb_ratio,
    input logic [4:0]        mulb_factor,
    input logic              mulb_ok,
    input logic [4:0]        mulc_factor,
    input logic              mulc_ok,
    input logic              mulc_err
);
    logic wr_hit, rd_req;
    always_comb wr_hit = bus_sel && bus_wr && (bus_addr == OFFSET);
    always_comb rd_req = bus_sel && !bus_wr && (bus_addr == OFFSET);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) bus_rdata[31:19] == 13'd0); // R2
    AST_LANE0_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (wr_hit && !bus_wstrb[0]) |=> ($stable(diva_ratio) && $stable(divb_ratio))); // R3
    AST_MAIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (wr_hit && pll_main_on) |=> $stable(diva_src_sel)); // R4
    AST_C_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (wr_hit && pll_c_on) |=> ($stable(mulc_factor) && $stable(mulc_ok))); // R5
    AST_B_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (wr_hit && pll_b_on) |=> ($stable(mulb_factor) && $stable(mulb_ok))); // R6
    AST_C_FACTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) mulc_ok |-> (mulc_factor inside {[5'd8:5'd14], 5'd16, 5'd20})); // R8
    AST_B_FACTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) mulb_ok |-> (mulb_factor inside {[5'd8:5'd14], 5'd16, 5'd20})); // R8
    AST_C_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) mulc_err |-> (mulc_factor == 5'd0 && !mulc_ok)); // R9
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !rd_req |-> (bus_rdata == 32'd0)); // R10
endmodule

bind clkcfg_lockreg clkcfg_chk #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_chk (.*);

// File: tb/tb_clkcfg_lockreg.sv
`timescale 1ns/1ps
// Directed bench for clkcfg_lockreg. Each scenario is a task that checks its
// own results against a reference word kept from the requirements.
module tb_clkcfg_lockreg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_rdata;
    logic        pll_main_on = 1'b0, pll_b_on = 1'b0, pll_c_on = 1'b0;
    logic        aud0_clk_sel, aud1_clk_sel, diva_src_sel;
    logic [3:0]  diva_ratio, divb_ratio;
    logic [4:0]  mulb_factor, mulc_factor;
    logic        mulb_ok, mulb_err, mulc_ok, mulc_err;

    int n_chk = 0, n_bad = 0;
    logic [31:0] ref_w = '0;
    localparam logic [7:0] OFS = 8'h2C;

    always #5 clk = ~clk;

    clkcfg_lockreg dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] mul_expect(input logic [3:0] c); // {ok, factor}
        case (c)
            4'd6: return {1'b1, 5'd8};   4'd7: return {1'b1, 5'd9};
            4'd8: return {1'b1, 5'd10};  4'd9: return {1'b1, 5'd11};
            4'd10: return {1'b1, 5'd12}; 4'd11: return {1'b1, 5'd13};
            4'd12: return {1'b1, 5'd14}; 4'd14: return {1'b1, 5'd16};
            4'd15: return {1'b1, 5'd20};
            default: return 6'd0;
        endcase
    endfunction

    // Bus write: drive at negedge, the register loads at the next posedge.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wstrb = '0;
        if (a == OFS) begin
            if (s[0]) ref_w[7:0] = d[7:0];
            if (s[1]) begin
                if (!pll_c_on) ref_w[15:12] = d[15:12];
                if (!pll_b_on) ref_w[11:8] = d[11:8];
            end
            if (s[2]) begin
                ref_w[18:17] = d[18:17];
                if (!pll_main_on) ref_w[16] = d[16];
            end
        end
    endtask

    // Same-cycle read, sampled 1 ns after the request is driven.
    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic check_word(input string tag);
        logic [31:0] r;
        bus_read(OFS, r);
        check(tag, r, ref_w);
    endtask

    task automatic check_outputs(input string tag);
        logic [5:0] eb, ec;
        eb = mul_expect(ref_w[11:8]);
        ec = mul_expect(ref_w[15:12]);
        check({tag, " R11 sel"}, {29'd0, aud1_clk_sel, aud0_clk_sel, diva_src_sel}, {29'd0, ref_w[18:16]});
        check({tag, " R11 div"}, {24'd0, divb_ratio, diva_ratio}, {24'd0, ref_w[7:0]});
        check({tag, " R8/R9 mulb"}, {25'd0, mulb_err, mulb_ok, mulb_factor}, {25'd0, ~eb[5], eb});
        check({tag, " R8/R9 mulc"}, {25'd0, mulc_err, mulc_ok, mulc_factor}, {25'd0, ~ec[5], ec});
    endtask

    task automatic t_reset();
        check_word("R1 reset word");
        check("R1 reset mulc", {25'd0, mulc_err, mulc_ok, mulc_factor}, {25'd0, 2'b10, 5'd0});
        check("R1 reset mulb", {25'd0, mulb_err, mulb_ok, mulb_factor}, {25'd0, 2'b10, 5'd0});
    endtask

    task automatic t_reserved_bits();
        bus_write(OFS, 32'hFFFF_FFFF, 4'hF);
        check_word("R2 upper bits zero");
        check("R2 exact", ref_w, 32'h0007_FFFF);
        check("R8 code 15 factor", {27'd0, mulc_factor}, 32'd20);
        check_outputs("R11 all ones");
    endtask

    task automatic t_strobes();
        bus_write(OFS, 32'h0000_0000, 4'b0001);
        check_word("R3 lane0 only");
        check("R3 lane0 value", ref_w, 32'h0007_FF00);
        bus_write(OFS, 32'h0000_1200, 4'b0010);
        check_word("R3 lane1 only");
        check_outputs("R3/R9 reserved codes");
        bus_write(OFS, 32'h0000_0000, 4'b0100);
        check_word("R3 lane2 only");
    endtask

    task automatic t_decode();
        for (int c = 0; c < 16; c++) begin
            bus_write(OFS, {16'd0, c[3:0], c[3:0], 8'h5A}, 4'b0011);
            check_outputs($sformatf("R8/R9 code %0d", c));
        end
    endtask

    task automatic t_locks();
        bus_write(OFS, 32'h0000_7700, 4'b0010);
        pll_c_on = 1'b1;
        bus_write(OFS, 32'h0000_A500, 4'b0010);
        check_word("R5/R7 C locked B updates");
        check("R5 mulc kept", {27'd0, mulc_factor}, 32'd9);
        check("R7 mulb taken", {31'd0, mulb_err}, 32'd1);
        pll_c_on = 1'b0; pll_b_on = 1'b1;
        bus_write(OFS, 32'h0000_EB00, 4'b0010);
        check_word("R6/R7 B locked C updates");
        check("R6 mulc now 16", {27'd0, mulc_factor}, 32'd16);
        pll_b_on = 1'b0; pll_main_on = 1'b1;
        bus_write(OFS, 32'h0007_0000, 4'b0100);
        check_word("R4/R7 main lock");
        check("R4 src held", {31'd0, diva_src_sel}, 32'd0);
        check("R7 aud taken", {30'd0, aud1_clk_sel, aud0_clk_sel}, 32'd3);
        pll_main_on = 1'b0;
        bus_write(OFS, 32'h0001_0000, 4'b0100);
        check("R4 unlocked src", {31'd0, diva_src_sel}, 32'd1);
        check_outputs("R4 after unlock");
    endtask

    task automatic t_addressing();
        logic [31:0] r;
        bus_write(8'h28, 32'hFFFF_FFFF, 4'hF);
        check_word("R10 other addr write ignored");
        bus_read(8'h30, r);
        check("R10 other addr read zero", r, 32'd0);
        @(negedge clk); #1;
        check("R10 idle rdata zero", bus_rdata, 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reserved_bits();
        t_strobes();
        t_decode();
        t_locks();
        t_addressing();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule